// File: doc/BRIEF.md
# Streaming 3x3 Convolution Engine

This block turns a 28x28 frame of unsigned 8-bit pixels, delivered one pixel at a time in raster order, into a 26x26 feature map of bytes. It produces one output pixel per clock. A start pulse opens each frame. The engine first pulls its nine signed 8-bit kernel coefficients out of a single-port weight memory into local registers. That memory answers two cycles after it is addressed.

Once the coefficients are held, the engine raises `ready` and accepts pixels. Two row buffers and a 3x3 register window present all nine neighbours of a pixel at once, and nine multipliers work on them in parallel. The sum of the nine products has no bias added to it. The sum is rectified, scaled down by 256 and saturated to a byte.

Outputs appear only for window positions that lie fully inside the frame. A single-cycle `done` pulse marks the end of the frame, and it comes only after the last result has left the pipeline. The engine is meant to sit between an image store that streams pixels and a downstream pooling stage.

Top module: `conv3x3_stream`

## Requirements
- R1: While reset is asserted, and after it is released until a start is sampled, `ready`, `wmem_rd`, `out_valid` and `done` are all low.
- R2: A start sampled while idle makes the block assert `wmem_rd` on nine consecutive cycles, with `wmem_addr` stepping from 0 to 8, one address per cycle, in ascending order.
- R3: The byte on `wmem_data` two cycles after address i is issued becomes kernel coefficient i. Coefficient i multiplies the pixel at row offset i/3 and column offset i%3 of the window, where offset 0,0 is the top-left (earliest) pixel. `ready` goes high on the 11th clock edge after the edge that samples start, and `wmem_rd` is never high while `ready` is high.
- R4: A pixel is taken only on a clock edge where both `ready` and `pix_valid` are high. Pixels offered while idle or during the coefficient load leave the results unchanged.
- R5: Each output byte equals the signed sum over nine taps of pixel times coefficient, with each pixel treated as unsigned 0..255. Results of zero or below give 0; otherwise the sum is shifted right by 8 and saturated at 255.
- R6: A frame yields exactly 676 outputs, in raster order of the window's top-left corner. A window whose bottom-right pixel has row < 2 or column < 2 yields no output, including the first two pixels of every row.
- R7: `out_valid` for a window is high exactly 3 cycles after the cycle in which the pixel completing that window is presented and accepted.
- R8: `done` is a one-cycle pulse, high in the cycle right after the last `out_valid`, which is 4 cycles after the cycle of the frame's last pixel. `ready` drops once the last pixel is accepted, and no `out_valid` follows `done`.
- R9: Idle cycles, where `pix_valid` is low between pixels, do not change any output value or the output order.
- R10: A start pulse while a frame is loading, streaming or draining is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a frame when the block is idle |
| wmem_rd | output | 1 | Weight memory read strobe |
| wmem_addr | output | ADDR_W (10) | Weight memory address |
| wmem_data | input | 8 | Weight memory read data, two cycles after the address |
| ready | output | 1 | High while pixels are accepted |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | 8 | Unsigned pixel value |
| out_valid | output | 1 | Output pixel strobe |
| out_data | output | 8 | Requantized output pixel |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench loads kernels that are asymmetric, so a design that latched coefficients one memory cycle early or late, or mapped taps in a transposed order, would give wrong bytes at almost every position. Frames made only of pixels at 255 show two faults: a design that sign-extended the pixels would rectify to zero, and one without saturation would wrap past 255. The bench counts the outputs of every frame, so a design that let the column wrap through would produce 52 extra results. It also times `done` against the last output, so a design that raised `done` before the pipeline had drained would show it. Some frames add idle cycles, stray pixels before `ready`, or a second start in mid-frame, and these must match the frames without them.

// File: rtl/conv3x3_pkg.sv
package conv3x3_pkg;
  localparam int KDIM       = 3;
  localparam int TAPS       = KDIM * KDIM;
  localparam int PIX_W      = 8;
  localparam int WT_W       = 8;
  localparam int OUT_W      = 8;
  localparam int SHIFT      = 8;
  localparam int PROD_W     = PIX_W + WT_W;
  localparam int ACC_W      = PROD_W + $clog2(TAPS);
  localparam int MAC_STAGES = 2;
  localparam int IDX_W      = $clog2(TAPS);

  localparam logic signed [ACC_W-1:0] ACC_OUT_MAX = ACC_W'((1 << OUT_W) - 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_STREAM,
    ST_DRAIN
  } eng_state_t;

  // Unsigned pixel times signed coefficient; the pixel gets a zero top bit.
  function automatic logic signed [PROD_W-1:0] tap_mul(
    input logic [PIX_W-1:0]        pix,
    input logic signed [WT_W-1:0]  coef
  );
    logic signed [PIX_W:0] pz;
    pz = signed'({1'b0, pix});
    return PROD_W'(pz) * PROD_W'(coef);
  endfunction

  // Rectify, scale down, saturate.
  function automatic logic [OUT_W-1:0] requant(
    input logic signed [ACC_W-1:0] acc
  );
    logic signed [ACC_W-1:0] sh;
    if (acc <= 0) return '0;
    sh = acc >>> SHIFT;
    if (sh > ACC_OUT_MAX) return {OUT_W{1'b1}};
    return sh[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/conv3x3_kload.sv
module conv3x3_kload
  import conv3x3_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int WT_BASE = 0,
  parameter int MEM_LAT = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go,
  output logic                        rd_en,
  output logic [ADDR_W-1:0]           rd_addr,
  input  logic [WT_W-1:0]             rd_data,
  output logic [TAPS-1:0][WT_W-1:0]   coefs,
  output logic                        loaded
);
  logic             issuing;
  logic [IDX_W-1:0] icnt;
  logic             pipe_v [MEM_LAT];
  logic [IDX_W-1:0] pipe_i [MEM_LAT];

  assign rd_en   = issuing;
  assign rd_addr = ADDR_W'(WT_BASE) + ADDR_W'(icnt);
  // last coefficient arrives this cycle
  assign loaded  = pipe_v[MEM_LAT-1] && (pipe_i[MEM_LAT-1] == IDX_W'(TAPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issuing <= 1'b0;
      icnt    <= '0;
      for (int k = 0; k < MEM_LAT; k++) begin
        pipe_v[k] <= 1'b0;
        pipe_i[k] <= '0;
      end
      for (int t = 0; t < TAPS; t++) coefs[t] <= '0;
    end else begin
      if (go) begin
        issuing <= 1'b1;
        icnt    <= '0;
      end else if (issuing) begin
        if (icnt == IDX_W'(TAPS - 1)) issuing <= 1'b0;
        icnt <= icnt + 1'b1;
      end
      pipe_v[0] <= issuing;
      pipe_i[0] <= icnt;
      for (int k = 1; k < MEM_LAT; k++) begin
        pipe_v[k] <= pipe_v[k-1];
        pipe_i[k] <= pipe_i[k-1];
      end
      if (pipe_v[MEM_LAT-1]) coefs[pipe_i[MEM_LAT-1]] <= rd_data;
    end
  end
endmodule

// File: rtl/conv3x3_window.sv
module conv3x3_window
  import conv3x3_pkg::*;
#(
  parameter int IMG_W = 28,
  parameter int IMG_H = 28
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        accept,
  input  logic [PIX_W-1:0]            pix,
  output logic [TAPS-1:0][PIX_W-1:0]  taps,
  output logic                        win_vld,
  output logic                        at_last
);
  localparam int COL_W = $clog2(IMG_W);
  localparam int ROW_W = $clog2(IMG_H);
  localparam int NLB   = KDIM - 1;

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic [PIX_W-1:0] lb_rd  [NLB];
  logic [PIX_W-1:0] col_in [KDIM];
  logic [PIX_W-1:0] win    [KDIM][KDIM];
  logic             corner_ok;
  logic             col_wrap;

  genvar j;
  for (j = 0; j < NLB; j++) begin : g_lb
    logic [PIX_W-1:0] mem [IMG_W];
    logic [PIX_W-1:0] wr_val;
    if (j == 0) begin : g_head
      assign wr_val = pix;
    end else begin : g_tail
      assign wr_val = lb_rd[j-1];
    end
    assign lb_rd[j] = mem[col];
    always_ff @(posedge clk) begin
      if (accept) mem[col] <= wr_val;
    end
  end

  genvar r, c;
  for (r = 0; r < KDIM; r++) begin : g_colin
    if (r == KDIM - 1) begin : g_new
      assign col_in[r] = pix;
    end else begin : g_old
      assign col_in[r] = lb_rd[KDIM-2-r];
    end
    for (c = 0; c < KDIM; c++) begin : g_tap
      assign taps[r*KDIM+c] = win[r][c];
    end
  end

  assign corner_ok = (row >= ROW_W'(KDIM - 1)) && (col >= COL_W'(KDIM - 1));
  assign col_wrap  = (col == COL_W'(IMG_W - 1));
  assign at_last   = accept && col_wrap && (row == ROW_W'(IMG_H - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col     <= '0;
      row     <= '0;
      win_vld <= 1'b0;
      for (int a = 0; a < KDIM; a++)
        for (int b = 0; b < KDIM; b++) win[a][b] <= '0;
    end else if (clear) begin
      col     <= '0;
      row     <= '0;
      win_vld <= 1'b0;
      for (int a = 0; a < KDIM; a++)
        for (int b = 0; b < KDIM; b++) win[a][b] <= '0;
    end else begin
      win_vld <= accept && corner_ok;
      if (accept) begin
        for (int a = 0; a < KDIM; a++) begin
          for (int b = 0; b < KDIM - 1; b++) win[a][b] <= win[a][b+1];
          win[a][KDIM-1] <= col_in[a];
        end
        if (col_wrap) begin
          col <= '0;
          row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/conv3x3_mac.sv
module conv3x3_mac
  import conv3x3_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_vld,
  input  logic [TAPS-1:0][PIX_W-1:0]  taps,
  input  logic [TAPS-1:0][WT_W-1:0]   coefs,
  output logic                        out_vld,
  output logic [OUT_W-1:0]            out_data
);
  logic signed [PROD_W-1:0] prod_q [TAPS];
  logic                     prod_vld;
  logic signed [ACC_W-1:0]  acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_vld <= 1'b0;
      for (int t = 0; t < TAPS; t++) prod_q[t] <= '0;
    end else begin
      prod_vld <= in_vld;
      for (int t = 0; t < TAPS; t++) prod_q[t] <= tap_mul(taps[t], coefs[t]);
    end
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS; t++) acc = acc + ACC_W'(prod_q[t]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld  <= prod_vld;
      out_data <= requant(acc);
    end
  end
endmodule

// File: rtl/conv3x3_stream.sv
module conv3x3_stream
  import conv3x3_pkg::*;
#(
  parameter int IMG_W   = 28,
  parameter int IMG_H   = 28,
  parameter int ADDR_W  = 10,
  parameter int WT_BASE = 0,
  parameter int MEM_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              wmem_rd,
  output logic [ADDR_W-1:0] wmem_addr,
  input  logic [WT_W-1:0]   wmem_data,
  output logic              ready,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic              done
);
  localparam int DRAIN_CYC = MAC_STAGES + 1;
  localparam int DCNT_W    = $clog2(DRAIN_CYC + 1);

  eng_state_t               state;
  logic [DCNT_W-1:0]        dcnt;
  logic                     go;
  logic                     accept;
  logic                     last_accept;
  logic                     load_done;
  logic                     win_vld;
  logic [TAPS-1:0][WT_W-1:0]  coefs;
  logic [TAPS-1:0][PIX_W-1:0] taps;

  assign go     = start && (state == ST_IDLE);
  assign accept = pix_valid && (state == ST_STREAM);
  assign ready  = (state == ST_STREAM);

  conv3x3_kload #(
    .ADDR_W (ADDR_W),
    .WT_BASE(WT_BASE),
    .MEM_LAT(MEM_LAT)
  ) u_kload (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .rd_en  (wmem_rd),
    .rd_addr(wmem_addr),
    .rd_data(wmem_data),
    .coefs  (coefs),
    .loaded (load_done)
  );

  conv3x3_window #(
    .IMG_W(IMG_W),
    .IMG_H(IMG_H)
  ) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (go),
    .accept (accept),
    .pix    (pix_data),
    .taps   (taps),
    .win_vld(win_vld),
    .at_last(last_accept)
  );

  conv3x3_mac u_mac (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (win_vld),
    .taps    (taps),
    .coefs   (coefs),
    .out_vld (out_valid),
    .out_data(out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      dcnt  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (go) state <= ST_LOAD;
        ST_LOAD: if (load_done) state <= ST_STREAM;
        ST_STREAM: begin
          if (last_accept) begin
            state <= ST_DRAIN;
            dcnt  <= '0;
          end
        end
        ST_DRAIN: begin
          if (dcnt == DCNT_W'(DRAIN_CYC - 1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/conv3x3_stream_chk.sv
module conv3x3_stream_chk #(
  parameter int ADDR_W  = 10,
  parameter int WT_BASE = 0,
  parameter int TAPS    = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              wmem_rd,
  input logic [ADDR_W-1:0] wmem_addr,
  input logic              pix_valid,
  input logic              out_valid,
  input logic              done,
  input logic              win_vld,
  input logic              accept,
  input logic              last_accept
);
  p_rd_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wmem_rd |-> (int'(wmem_addr) >= WT_BASE) && (int'(wmem_addr) < WT_BASE + TAPS));

  p_rd_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wmem_rd && $past(wmem_rd)) |-> (wmem_addr == $past(wmem_addr) + ADDR_W'(1)));

  p_no_rd_when_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !wmem_rd);

  p_accept_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (ready && pix_valid));

  p_window_to_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> ##2 out_valid);

  p_output_from_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(win_vld, 2));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid) && !out_valid));

  p_last_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_accept |=> !ready);
endmodule

bind conv3x3_stream conv3x3_stream_chk #(
  .ADDR_W (ADDR_W),
  .WT_BASE(WT_BASE),
  .TAPS   (TAPS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .wmem_rd    (wmem_rd),
  .wmem_addr  (wmem_addr),
  .pix_valid  (pix_valid),
  .out_valid  (out_valid),
  .done       (done),
  .win_vld    (win_vld),
  .accept     (accept),
  .last_accept(last_accept)
);

// File: tb/conv3x3_stream_test.sv
module conv3x3_stream_test;
  localparam int W    = 28;
  localparam int H    = 28;
  localparam int OW   = W - 2;
  localparam int OH   = H - 2;
  localparam int NOUT = OW * OH;

  typedef struct packed {
    logic [3:0] kmode;
    logic [3:0] imode;
    logic       gap;     // R9 bubbles
    logic       midstart;// R10 stray start
    logic       junk;    // R4 pixels before ready
    logic [9:0] nout;    // expected output count
  } case_t;

  localparam int NCASE = 7;
  localparam case_t CASES [NCASE] = '{
    '{4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 10'd676},
    '{4'd1, 4'd1, 1'b0, 1'b0, 1'b0, 10'd676},
    '{4'd2, 4'd0, 1'b0, 1'b0, 1'b0, 10'd676},
    '{4'd3, 4'd1, 1'b0, 1'b0, 1'b0, 10'd676},
    '{4'd4, 4'd3, 1'b1, 1'b1, 1'b0, 10'd676},
    '{4'd5, 4'd2, 1'b0, 1'b0, 1'b1, 10'd676},
    '{4'd4, 4'd0, 1'b1, 1'b0, 1'b1, 10'd676}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       wmem_rd;
  logic [9:0] wmem_addr;
  logic [7:0] wmem_data;
  logic       ready;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_data = 8'h00;
  logic       out_valid;
  logic [7:0] out_data;
  logic       done;

  always #(2.5ns) clk = ~clk;

  conv3x3_stream uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .wmem_rd  (wmem_rd),
    .wmem_addr(wmem_addr),
    .wmem_data(wmem_data),
    .ready    (ready),
    .pix_valid(pix_valid),
    .pix_data (pix_data),
    .out_valid(out_valid),
    .out_data (out_data),
    .done     (done)
  );

  // weight memory with two-cycle read latency
  logic [7:0] kmem [16];
  logic [7:0] mrd1 = 8'h00;
  logic [7:0] mrd0 = 8'h00;
  always @(posedge clk) begin
    mrd1 <= wmem_rd ? kmem[wmem_addr[3:0]] : 8'h00;
    mrd0 <= mrd1;
  end
  assign wmem_data = mrd0;

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int img_val(int mode, int r, int c);
    case (mode)
      0:       return (r * 7 + c * 13) & 255;
      1:       return 255;
      2:       return ((r + c) & 1) ? 250 : 5;
      default: return ((r * r + 3 * c) * 11) & 255;
    endcase
  endfunction

  function automatic int kval(int mode, int i);
    case (mode)
      0:       return 1;
      1:       return 127;
      2:       return -1;
      3:       return (i == 4) ? 64 : 0;
      4:       return ((i * 37) % 97) - 48;
      default: return (i == 0) ? 100 : ((i == 8) ? -100 : 0);
    endcase
  endfunction

  function automatic int ref_px(int km, int im, int r, int c);
    int s = 0;
    for (int dr = 0; dr < 3; dr++)
      for (int dc = 0; dc < 3; dc++)
        s += img_val(im, r + dr, c + dc) * kval(km, dr * 3 + dc);
    if (s <= 0) return 0;
    s = s / 256;
    return (s > 255) ? 255 : s;
  endfunction

  int  exp_q [NOUT];
  bit  mon_on = 1'b0;
  int  rd_idx, oidx, first_out_cyc, last_out_cyc, done_cyc, frame_err;
  bit  done_seen, late_out;

  always @(negedge clk) begin
    if (mon_on) begin
      if (wmem_rd) begin
        chk(int'(wmem_addr) == rd_idx, "R2", "weight address", int'(wmem_addr), rd_idx);
        rd_idx++;
      end
      if (out_valid) begin
        if (done_seen) late_out = 1'b1;
        if (oidx < NOUT) begin
          if (int'(out_data) != exp_q[oidx]) frame_err++;
          chk(int'(out_data) == exp_q[oidx], "R5", "output byte", int'(out_data), exp_q[oidx]);
        end
        if (oidx == 0) first_out_cyc = cyc;
        last_out_cyc = cyc;
        oidx++;
      end
      if (done) begin
        if (done_seen) chk(1'b0, "R8", "second done pulse", 1, 0);
        done_seen = 1'b1;
        done_cyc  = cyc;
      end
    end
  end

  task automatic run_frame(input case_t cs);
    int c0, p22_cyc, last_cyc, rdy_cyc;
    for (int i = 0; i < 16; i++) kmem[i] = (i < 9) ? 8'(kval(int'(cs.kmode), i)) : 8'h00;
    for (int r = 0; r < OH; r++)
      for (int c = 0; c < OW; c++)
        exp_q[r * OW + c] = ref_px(int'(cs.kmode), int'(cs.imode), r, c);
    rd_idx = 0; oidx = 0; first_out_cyc = -1; last_out_cyc = -1;
    done_cyc = -1; frame_err = 0; done_seen = 1'b0; late_out = 1'b0;
    mon_on = 1'b1;
    @(negedge clk);
    if (cs.junk) begin
      pix_valid = 1'b1;   // R4: offered while idle
      pix_data  = 8'd200;
      @(negedge clk);
    end
    start = 1'b1;
    c0 = cyc;
    @(negedge clk);
    start = 1'b0;
    rdy_cyc = -1;
    for (int t = 0; t < 40; t++) begin
      if (ready) begin
        rdy_cyc = cyc;
        break;
      end
      @(negedge clk);
    end
    chk(rdy_cyc == c0 + 12, "R3", "ready timing", rdy_cyc - c0, 12);
    chk(rd_idx == 9, "R2", "weight reads", rd_idx, 9);
    p22_cyc = -1; last_cyc = -1;
    for (int i = 0; i < W * H; i++) begin
      if (cs.gap && (i % 5 == 2)) begin
        pix_valid = 1'b0;  // R9 bubble
        @(negedge clk);
      end
      pix_valid = 1'b1;
      pix_data  = 8'(img_val(int'(cs.imode), i / W, i % W));
      if (cs.midstart && i == 300) start = 1'b1;  // R10
      if (i == 2 * W + 2) p22_cyc = cyc;
      last_cyc = cyc;
      @(negedge clk);
      start = 1'b0;
    end
    pix_valid = 1'b0;
    chk(!ready, "R8", "ready after last pixel", int'(ready), 0);
    repeat (10) @(negedge clk);
    mon_on = 1'b0;
    chk(oidx == int'(cs.nout), "R6", "output count", oidx, int'(cs.nout));
    chk(first_out_cyc == p22_cyc + 3, "R7", "first output latency",
        first_out_cyc - p22_cyc, 3);
    chk(done_seen && done_cyc == last_out_cyc + 1, "R8", "done after last output",
        done_cyc - last_out_cyc, 1);
    chk(done_cyc == last_cyc + 4, "R8", "done after last pixel", done_cyc - last_cyc, 4);
    chk(!late_out, "R8", "output after done", int'(late_out), 0);
    if (cs.junk)     chk(frame_err == 0, "R4", "frame with stray pixels", frame_err, 0);
    if (cs.gap)      chk(frame_err == 0, "R9", "frame with bubbles", frame_err, 0);
    if (cs.midstart) chk(frame_err == 0, "R10", "frame with stray start", frame_err, 0);
  endtask

  task automatic idle_check(input string what);
    chk(!ready && !wmem_rd && !out_valid && !done, "R1", what,
        int'({ready, wmem_rd, out_valid, done}), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) kmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    idle_check("outputs in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle_check("outputs after reset");

    for (int n = 0; n < NCASE; n++) run_frame(CASES[n]);

    // reset in mid-stream, then a clean frame
    for (int i = 0; i < 16; i++) kmem[i] = (i < 9) ? 8'(kval(4, i)) : 8'h00;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 40 && !ready; t++) @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      pix_valid = 1'b1;
      pix_data  = 8'(i);
      @(negedge clk);
    end
    pix_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    idle_check("outputs in mid-frame reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    idle_check("outputs after mid-frame reset");
    run_frame(CASES[4]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule